// File: doc/BRIEF.md
# Display RAM Address Pointer

This block produces the bank and column address for a column-driver display RAM that holds four banks of forty bytes, each byte covering eight rows of one column. Several such drivers are chained on one bus, and they all track the same position. A command side sets where a transfer starts: a chip number, a column, a bank, and one of three traversal orders. After that, every data byte advances the pointer by one step in the selected order. When one chip's range is used up, the chip counter moves on to the next chip.

The chip counter is compared with the four strap pins of this chip. A local-select flag tells the RAM that this chip owns the current byte, so that the RAM stores or returns it. The pointer advances on every byte whether or not the chip is selected, so every chip in the chain stays in step.

The traversal order is held in a small state machine with three states. `MODE_CHAR` steps through all four banks at a fixed column. `MODE_HALF` steps through a pair of banks at a fixed column. `MODE_FULL` steps along the columns of one bank. There is one transition: an access command moves the machine from any state to the state that its mode code selects. Reserved code 11 leads to `MODE_FULL`. In every other cycle the machine stays in its current state.

Top module: `addr_pointer`

## Requirements
- R1: After reset, `bank` and `col` are 0, the chip counter is 0 (so `local_sel` is 1 exactly when `hw_sub` is 0), and the order is character (`MODE_CHAR`).
- R2: With mode code 10 (full-graphic), each byte strobe moves `col` up by one. From column 39 it returns to column 0 and `bank` moves up by one. From bank 3 at column 39 it goes to bank 0, column 0, and the chip counter moves up by one.
- R3: With mode code 01 (half-graphic), the pointer takes banks 2p and 2p+1 in turn at one column before it moves to the next column. After column 39 of bank 2p+1 it moves to bank 2p+2 at column 0. After bank 3 at column 39 it goes to bank 0, column 0, with the chip counter moved up by one.
- R4: With mode code 00 (character), each strobe moves `bank` up by one. After bank 3 the pointer goes to bank 0 at the next column. After bank 3 at column 39 it goes to bank 0, column 0, with the chip counter moved up by one.
- R5: Mode code 11 gives exactly the full-graphic order.
- R6: The chip counter is 4 bits wide and goes from 15 to 0 when it steps. It steps whether or not `local_sel` is high.
- R7: `local_sel` is 1 exactly when the chip counter equals `hw_sub`. It follows a change of `hw_sub` within the same cycle.
- R8: A load of the chip number (`ld_dev`), the column (`ld_x`), or the bank and mode (`ld_acc`) takes effect on the next clock edge. If any load is asserted together with `byte_stb`, the loads apply and the pointer does not step in that cycle.
- R9: Without a strobe or a load, `bank`, `col` and the chip counter hold their values.
- R10: A column load with a value of 40 or more sets `col` to 0, so `col` is always below 40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_dev | input | 1 | Load the chip counter from `dev_val` |
| dev_val | input | 4 | Chip number to load |
| ld_x | input | 1 | Load the column from `x_val` |
| x_val | input | 6 | Column to load |
| ld_acc | input | 1 | Load the bank and the traversal mode |
| acc_bank | input | 2 | Bank to load |
| acc_mode | input | 2 | Mode code: 00 character, 01 half-graphic, 10 full-graphic, 11 full-graphic |
| byte_stb | input | 1 | One data byte transferred; advance the pointer |
| hw_sub | input | 4 | Strap pins that give this chip's number |
| bank | output | 2 | Current RAM bank |
| col | output | 6 | Current RAM column |
| local_sel | output | 1 | The chip counter equals `hw_sub` |

## Verification
The bench builds the block with its default parameters: 40 columns, 4 banks and a 4-bit chip counter. This makes a full device range 160 bytes long. Each traversal run of 160 to 200 strobes therefore crosses every column wrap, every bank wrap and at least one chip-counter step. The narrow chip counter also makes the step from 15 to 0 reachable with a single load. The even bank count enables the half-graphic order, so both the move inside a bank pair and the move to the next pair are exercised.

// File: rtl/addr_ptr_pkg.sv
package addr_ptr_pkg;

    typedef enum logic [1:0] {
        MODE_CHAR = 2'b00,
        MODE_HALF = 2'b01,
        MODE_FULL = 2'b10
    } mode_e;

    // Reserved code 11 resolves to the column-first order.
    function automatic mode_e decode_mode(input logic [1:0] code);
        mode_e m;
        unique case (code)
            2'b00:   m = MODE_CHAR;
            2'b01:   m = MODE_HALF;
            default: m = MODE_FULL;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/addr_mode_fsm.sv
module addr_mode_fsm
    import addr_ptr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ld_acc,
    input  logic [1:0]  acc_mode,
    output mode_e       mode
);

    mode_e state_q;
    mode_e state_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MODE_CHAR;
        end else begin
            state_q <= state_n;
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            MODE_CHAR: if (ld_acc) state_n = decode_mode(acc_mode);
            MODE_HALF: if (ld_acc) state_n = decode_mode(acc_mode);
            MODE_FULL: if (ld_acc) state_n = decode_mode(acc_mode);
            default:   state_n = MODE_CHAR;
        endcase
    end

    always_comb begin
        mode = state_q;
    end

endmodule

// File: rtl/addr_step.sv
module addr_step
    import addr_ptr_pkg::*;
#(
    parameter int NUM_COLS  = 40,
    parameter int NUM_BANKS = 4,
    parameter int SUB_W     = 4,
    localparam int COL_W    = $clog2(NUM_COLS),
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  mode_e             mode,
    input  logic [COL_W-1:0]  x,
    input  logic [BANK_W-1:0] bank,
    input  logic [SUB_W-1:0]  sub,
    output logic [COL_W-1:0]  nx,
    output logic [BANK_W-1:0] nbank,
    output logic [SUB_W-1:0]  nsub
);

    logic x_last;
    logic bank_last;

    assign x_last    = (x == COL_W'(NUM_COLS - 1));
    assign bank_last = (bank == BANK_W'(NUM_BANKS - 1));

    // Column-first walk, shared by the full order and by the fallback
    // for the pair order when the bank count is odd.
    logic [COL_W-1:0]  fx;
    logic [BANK_W-1:0] fbank;
    logic [SUB_W-1:0]  fsub;

    always_comb begin
        fx    = x;
        fbank = bank;
        fsub  = sub;
        if (!x_last) begin
            fx = x + 1'b1;
        end else begin
            fx = '0;
            if (bank_last) begin
                fbank = '0;
                fsub  = sub + 1'b1;
            end else begin
                fbank = bank + 1'b1;
            end
        end
    end

    logic [COL_W-1:0]  hx;
    logic [BANK_W-1:0] hbank;
    logic [SUB_W-1:0]  hsub;

    generate
        if ((NUM_BANKS % 2) == 0) begin : g_pair
            always_comb begin
                hx    = x;
                hbank = bank;
                hsub  = sub;
                if (!bank[0]) begin
                    hbank = bank + 1'b1;
                end else if (!x_last) begin
                    hbank = bank - 1'b1;
                    hx    = x + 1'b1;
                end else begin
                    hx = '0;
                    if (bank_last) begin
                        hbank = '0;
                        hsub  = sub + 1'b1;
                    end else begin
                        hbank = bank + 1'b1;
                    end
                end
            end
        end else begin : g_no_pair
            always_comb begin
                hx    = fx;
                hbank = fbank;
                hsub  = fsub;
            end
        end
    endgenerate

    logic [COL_W-1:0]  cx;
    logic [BANK_W-1:0] cbank;
    logic [SUB_W-1:0]  csub;

    always_comb begin
        cx    = x;
        cbank = bank;
        csub  = sub;
        if (!bank_last) begin
            cbank = bank + 1'b1;
        end else begin
            cbank = '0;
            if (!x_last) begin
                cx = x + 1'b1;
            end else begin
                cx   = '0;
                csub = sub + 1'b1;
            end
        end
    end

    always_comb begin
        unique case (mode)
            MODE_CHAR: begin nx = cx; nbank = cbank; nsub = csub; end
            MODE_HALF: begin nx = hx; nbank = hbank; nsub = hsub; end
            MODE_FULL: begin nx = fx; nbank = fbank; nsub = fsub; end
            default:   begin nx = fx; nbank = fbank; nsub = fsub; end
        endcase
    end

endmodule

// File: rtl/addr_pos_reg.sv
module addr_pos_reg #(
    parameter int NUM_COLS  = 40,
    parameter int NUM_BANKS = 4,
    parameter int SUB_W     = 4,
    localparam int COL_W    = $clog2(NUM_COLS),
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_dev,
    input  logic [SUB_W-1:0]  dev_val,
    input  logic              ld_x,
    input  logic [COL_W-1:0]  x_val,
    input  logic              ld_acc,
    input  logic [BANK_W-1:0] acc_bank,
    input  logic              byte_stb,
    input  logic [COL_W-1:0]  nx,
    input  logic [BANK_W-1:0] nbank,
    input  logic [SUB_W-1:0]  nsub,
    output logic [COL_W-1:0]  x_q,
    output logic [BANK_W-1:0] bank_q,
    output logic [SUB_W-1:0]  sub_q
);

    localparam logic [COL_W:0] COL_LIM = (COL_W + 1)'(NUM_COLS);

    logic             any_ld;
    logic [COL_W-1:0] x_clip;

    assign any_ld = ld_dev | ld_x | ld_acc;
    assign x_clip = ({1'b0, x_val} < COL_LIM) ? x_val : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q    <= '0;
            bank_q <= '0;
            sub_q  <= '0;
        end else if (any_ld) begin
            if (ld_dev) sub_q  <= dev_val;
            if (ld_x)   x_q    <= x_clip;
            if (ld_acc) bank_q <= acc_bank;
        end else if (byte_stb) begin
            x_q    <= nx;
            bank_q <= nbank;
            sub_q  <= nsub;
        end
    end

endmodule

// File: rtl/addr_pointer.sv
module addr_pointer
    import addr_ptr_pkg::*;
#(
    parameter int NUM_COLS  = 40,
    parameter int NUM_BANKS = 4,
    parameter int SUB_W     = 4,
    localparam int COL_W    = $clog2(NUM_COLS),
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_dev,
    input  logic [SUB_W-1:0]  dev_val,
    input  logic              ld_x,
    input  logic [COL_W-1:0]  x_val,
    input  logic              ld_acc,
    input  logic [BANK_W-1:0] acc_bank,
    input  logic [1:0]        acc_mode,
    input  logic              byte_stb,
    input  logic [SUB_W-1:0]  hw_sub,
    output logic [BANK_W-1:0] bank,
    output logic [COL_W-1:0]  col,
    output logic              local_sel
);

    mode_e             mode_q;
    logic [COL_W-1:0]  x_q;
    logic [BANK_W-1:0] bank_q;
    logic [SUB_W-1:0]  sub_q;
    logic [COL_W-1:0]  nx;
    logic [BANK_W-1:0] nbank;
    logic [SUB_W-1:0]  nsub;

    addr_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_acc   (ld_acc),
        .acc_mode (acc_mode),
        .mode     (mode_q)
    );

    addr_step #(
        .NUM_COLS  (NUM_COLS),
        .NUM_BANKS (NUM_BANKS),
        .SUB_W     (SUB_W)
    ) u_step (
        .mode  (mode_q),
        .x     (x_q),
        .bank  (bank_q),
        .sub   (sub_q),
        .nx    (nx),
        .nbank (nbank),
        .nsub  (nsub)
    );

    addr_pos_reg #(
        .NUM_COLS  (NUM_COLS),
        .NUM_BANKS (NUM_BANKS),
        .SUB_W     (SUB_W)
    ) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_dev   (ld_dev),
        .dev_val  (dev_val),
        .ld_x     (ld_x),
        .x_val    (x_val),
        .ld_acc   (ld_acc),
        .acc_bank (acc_bank),
        .byte_stb (byte_stb),
        .nx       (nx),
        .nbank    (nbank),
        .nsub     (nsub),
        .x_q      (x_q),
        .bank_q   (bank_q),
        .sub_q    (sub_q)
    );

    assign bank      = bank_q;
    assign col       = x_q;
    assign local_sel = (sub_q == hw_sub);

endmodule

// File: rtl/addr_pointer_chk.sv
module addr_pointer_chk #(
    parameter int NUM_COLS  = 40,
    parameter int NUM_BANKS = 4,
    parameter int SUB_W     = 4,
    localparam int COL_W    = $clog2(NUM_COLS),
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_dev,
    input logic [SUB_W-1:0]  dev_val,
    input logic              ld_x,
    input logic [COL_W-1:0]  x_val,
    input logic              ld_acc,
    input logic              byte_stb,
    input logic [SUB_W-1:0]  hw_sub,
    input logic [BANK_W-1:0] bank,
    input logic [COL_W-1:0]  col,
    input logic              local_sel,
    input logic [1:0]        mode
);

    logic no_ld;
    assign no_ld = !(ld_dev || ld_x || ld_acc);

    // R10
    col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, col} < (COL_W + 1)'(NUM_COLS));

    // R8
    ld_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_x && ({1'b0, x_val} < (COL_W + 1)'(NUM_COLS))) |=> (col == $past(x_val)));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (no_ld && !byte_stb) |=> ($stable(col) && $stable(bank)));

    // R2
    full_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && no_ld && mode == 2'b10 && col != COL_W'(NUM_COLS - 1))
        |=> (col == $past(col) + 1'b1 && $stable(bank)));

    // R4
    char_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && no_ld && mode == 2'b00 && bank != BANK_W'(NUM_BANKS - 1))
        |=> (bank == $past(bank) + 1'b1 && $stable(col)));

    // R7
    dev_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_dev |=> (!$stable(hw_sub) || local_sel == ($past(dev_val) == hw_sub)));

endmodule

bind addr_pointer addr_pointer_chk #(
    .NUM_COLS  (NUM_COLS),
    .NUM_BANKS (NUM_BANKS),
    .SUB_W     (SUB_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_dev    (ld_dev),
    .dev_val   (dev_val),
    .ld_x      (ld_x),
    .x_val     (x_val),
    .ld_acc    (ld_acc),
    .byte_stb  (byte_stb),
    .hw_sub    (hw_sub),
    .bank      (bank),
    .col       (col),
    .local_sel (local_sel),
    .mode      (mode_q)
);

// File: tb/sim_addr_pointer.sv
`timescale 1ns/1ps
module sim_addr_pointer;

    localparam int NC = 40;
    localparam int NB = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld_dev = 1'b0;
    logic [3:0] dev_val = '0;
    logic       ld_x = 1'b0;
    logic [5:0] x_val = '0;
    logic       ld_acc = 1'b0;
    logic [1:0] acc_bank = '0;
    logic [1:0] acc_mode = '0;
    logic       byte_stb = 1'b0;
    logic [3:0] hw_sub = '0;
    logic [1:0] bank;
    logic [5:0] col;
    logic       local_sel;

    always #2.5 clk = ~clk;

    addr_pointer u0 (
        .clk(clk), .rst_n(rst_n), .ld_dev(ld_dev), .dev_val(dev_val),
        .ld_x(ld_x), .x_val(x_val), .ld_acc(ld_acc), .acc_bank(acc_bank),
        .acc_mode(acc_mode), .byte_stb(byte_stb), .hw_sub(hw_sub),
        .bank(bank), .col(col), .local_sel(local_sel)
    );

    typedef struct {
        int    b;
        int    c;
        bit    s;
        string r;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    // Reference position kept as linear indices per order.
    int m_x = 0, m_b = 0, m_sub = 0, m_mode = 0;

    function automatic void model_step();
        int idx, pair, r;
        if (m_mode == 1) begin
            pair = m_b / 2;
            idx  = pair * 2 * NC + m_x * 2 + (m_b % 2) + 1;
            if (idx == NB * NC) begin idx = 0; m_sub = (m_sub + 1) % 16; end
            pair = idx / (2 * NC);
            r    = idx % (2 * NC);
            m_x  = r / 2;
            m_b  = pair * 2 + r % 2;
        end else if (m_mode == 0) begin
            idx = m_x * NB + m_b + 1;
            if (idx == NB * NC) begin idx = 0; m_sub = (m_sub + 1) % 16; end
            m_x = idx / NB;
            m_b = idx % NB;
        end else begin
            idx = m_b * NC + m_x + 1;
            if (idx == NB * NC) begin idx = 0; m_sub = (m_sub + 1) % 16; end
            m_b = idx / NC;
            m_x = idx % NC;
        end
    endfunction

    task automatic op(input string r, input bit ldd, input int dv, input bit ldx,
                      input int xv, input bit lda, input int bv, input int mv,
                      input bit stb, input int hw);
        exp_t e;
        ld_dev   = ldd;  dev_val  = 4'(dv);
        ld_x     = ldx;  x_val    = 6'(xv);
        ld_acc   = lda;  acc_bank = 2'(bv); acc_mode = 2'(mv);
        byte_stb = stb;  hw_sub   = 4'(hw);
        if (ldd || ldx || lda) begin
            if (ldd) m_sub = dv;
            if (ldx) m_x = (xv < NC) ? xv : 0;
            if (lda) begin m_b = bv; m_mode = mv; end
        end else if (stb) begin
            model_step();
        end
        e.b = m_b; e.c = m_x; e.s = (m_sub == hw); e.r = r;
        q.push_back(e);
        @(negedge clk);
        ld_dev = 1'b0; ld_x = 1'b0; ld_acc = 1'b0; byte_stb = 1'b0;
    endtask

    // Monitor: compares each expected item after the edge it belongs to.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (int'(bank) != e.b || int'(col) != e.c || local_sel != e.s) begin
                    errors++;
                    $display("FAIL %s: bank=%0d col=%0d sel=%0d expected bank=%0d col=%0d sel=%0d",
                             e.r, bank, col, local_sel, e.b, e.c, e.s);
                end
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values observed before any command
        checks++;
        if (bank != 0 || col != 0 || local_sel != 1'b1) begin
            errors++;
            $display("FAIL R1: bank=%0d col=%0d sel=%0d expected 0 0 1", bank, col, local_sel);
        end
        // R1: default order is character (bank steps first)
        op("R1", 0, 0, 0, 0, 0, 0, 0, 1, 0);
        // R9: idle cycles hold
        op("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        op("R9", 0, 0, 0, 0, 0, 0, 0, 0, 3);
        // R2: full order through column, bank and chip wraps
        op("R8", 1, 5, 1, 38, 1, 0, 2, 0, 5);
        for (int i = 0; i < 170; i++) op("R2", 0, 0, 0, 0, 0, 0, 0, 1, 5);
        // R3: pair order
        op("R8", 0, 0, 1, 37, 1, 2, 1, 0, 6);
        for (int i = 0; i < 180; i++) op("R3", 0, 0, 0, 0, 0, 0, 0, 1, 6);
        // R4: character order
        op("R8", 0, 0, 1, 30, 1, 1, 0, 0, 7);
        for (int i = 0; i < 200; i++) op("R4", 0, 0, 0, 0, 0, 0, 0, 1, 7);
        // R5: reserved code acts as full order
        op("R8", 0, 0, 1, 0, 1, 0, 3, 0, 7);
        for (int i = 0; i < 45; i++) op("R5", 0, 0, 0, 0, 0, 0, 0, 1, 7);
        // R6: chip counter 15 wraps to 0, steps while deselected
        op("R6", 1, 15, 1, 39, 1, 3, 2, 0, 2);
        op("R6", 0, 0, 0, 0, 0, 0, 0, 1, 0);
        op("R6", 0, 0, 0, 0, 0, 0, 0, 1, 0);
        // R7: select follows hw_sub
        for (int i = 0; i < 20; i++) op("R7", 0, 0, 0, 0, 0, 0, 0, 0, i % 16);
        op("R7", 1, 9, 0, 0, 0, 0, 0, 0, 9);
        op("R7", 0, 0, 0, 0, 0, 0, 0, 0, 8);
        // R8: load wins over a strobe in the same cycle
        op("R8", 0, 0, 1, 10, 0, 0, 0, 1, 9);
        op("R8", 0, 0, 0, 0, 1, 2, 0, 1, 9);
        op("R8", 1, 4, 0, 0, 0, 0, 0, 1, 4);
        // R10: out-of-range column load
        op("R10", 0, 0, 1, 45, 0, 0, 0, 0, 4);
        op("R10", 0, 0, 1, 63, 0, 0, 0, 1, 4);
        op("R10", 0, 0, 1, 39, 0, 0, 0, 0, 4);
        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule